// File: doc/BRIEF.md
# Virtual Interrupt Enable Access Arbiter

This block sits beside a processor's system-instruction path and settles what happens when software reads or writes the group-0 interrupt enable register through a coprocessor-style instruction. A request arrives already registered, carrying its opcode fields, a read/write flag and write data. The block weighs the requester's privilege level against the platform's level presence, the hypervisor controls, the routing of fast interrupts to the top level, the secure-debug undefined controls and the per-level register-interface enables. It then gives the request exactly one outcome.

The five outcomes are undefined, trap to level 2, trap to level 3, access to the virtual enable copy, and access to the physical enable copy. The block holds both one-bit enable copies. It answers one cycle after each matching request with a one-hot outcome, a trap target, a syndrome class and read data. Taking the exception is left to the consumer of the response.

Top module: `venab_arbiter`

## Requirements
- R1: Only a request with `req_valid_i`=1, coprocessor 15, op1=0, CRn=12, CRm=12 and op2=6 is accepted. Both reads and writes use this encoding. Any other cycle gives `rsp_valid_o`=0 one cycle later, and the enables are not touched.
- R2: An accepted request at privilege 0 is undefined. So is an accepted request at any privilege when `feat_l1_i`=0 or `feat_sysif_i`=0.
- R3: At privilege 1 the checks are tried in this order:
  - Undefined when `sdu_prio_i`, `l3_present_i` and `route_fast_l3_i` are all 1. When `l3_narrow_i`=1, this check also needs `mon_mode_i`=0.
  - Trap to level 2 when `l2_present_i` and `hyp_cp12_trap_i` are both 1.
  - Undefined when `sysif_en_i[0]`=0.
  - Trap to level 2 when `l2_present_i` and `hyp_trap_g0_i` are both 1.
- R4: At privilege 1, once the R3 checks pass, the request is resolved as follows:
  - It goes to the virtual copy when `l2_present_i` and `hyp_virt_fast_i` are both 1.
  - Otherwise, when fast interrupts are routed to level 3 (same monitor-mode condition as R3), it is undefined if `sdu_undef_i`=1 and a trap to level 3 if not.
  - Otherwise it goes to the physical copy.
- R5: At privilege 2 the checks are tried in this order:
  - Undefined when `sdu_prio_i`, `l3_present_i` and `route_fast_l3_i` are all 1.
  - Undefined when `sysif_en_i[1]`=0.
  - When routed to level 3: undefined if `sdu_undef_i`=1, a trap to level 3 if not.
  - Otherwise it goes to the physical copy.
- R6: At privilege 3 a request is undefined when `sysif_en_i[2]`=0. Otherwise it goes to the physical copy.
- R7: The response appears exactly one cycle after an accepted request.
  - `rsp_outcome_o` is one-hot: bit0 undefined, bit1 trap level 2, bit2 trap level 3, bit3 virtual, bit4 physical.
  - A trap to level 2 gives `rsp_target_o`=2; a trap to level 3 gives 3. Both traps give `rsp_class_o`=0x03.
  - Any other outcome gives 0 on both fields.
- R8: For a read that accesses a copy, `rsp_rdata_o` is that copy's enable in bit 0 with bits 31:1 zero. It is zero for writes and for undefined or trapped outcomes.
- R9: A write changes only the copy its outcome selects, storing write data bit 0 and ignoring bits 31:1. A write that is undefined or trapped leaves both enables unchanged.
- R10: Reset clears both enables and the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cp_i | input | 4 | Coprocessor number |
| req_op1_i | input | 3 | First opcode field |
| req_crn_i | input | 4 | Primary register field |
| req_crm_i | input | 4 | Secondary register field |
| req_op2_i | input | 3 | Second opcode field |
| req_wdata_i | input | 32 | Write data |
| priv_i | input | 2 | Current privilege level 0..3 |
| mon_mode_i | input | 1 | Monitor mode active |
| l2_present_i | input | 1 | Level 2 implemented and enabled |
| l3_present_i | input | 1 | Level 3 implemented |
| l3_narrow_i | input | 1 | Level 3 runs the 32-bit state |
| feat_l1_i | input | 1 | 32-bit level-1 support present |
| feat_sysif_i | input | 1 | Interrupt-controller register interface present |
| hyp_cp12_trap_i | input | 1 | Hypervisor trap of coprocessor-12 space |
| hyp_trap_g0_i | input | 1 | Hypervisor trap of all group-0 accesses |
| hyp_virt_fast_i | input | 1 | Hypervisor virtualizes fast interrupts |
| route_fast_l3_i | input | 1 | Fast interrupts routed to level 3 |
| sdu_prio_i | input | 1 | Secure-debug undefined takes priority |
| sdu_undef_i | input | 1 | Secure-debug undefined in force |
| sysif_en_i | input | 3 | Register-interface enable per level (bit0 L1, bit1 L2, bit2 L3) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_outcome_o | output | 5 | One-hot outcome |
| rsp_target_o | output | 2 | Trap target level |
| rsp_class_o | output | 6 | Syndrome class |
| rsp_rdata_o | output | 32 | Read data |
| virt_en_o | output | 1 | Virtual group-0 enable |
| phys_en_o | output | 1 | Physical group-0 enable |

## Verification
Directed sequences at privilege 1 turn on one control at a time, from the lowest-priority control upward. Each added control must take over the outcome, which shows each check outranks the ones below it. Writes of 1 and then 0 go through each outcome, and reads follow each write. These tell apart a write that reaches the selected copy, one that leaks into the other copy, and one that leaks past a trap. Near-miss encodings and idle cycles separate accepted from ignored requests. A long run of random controls at all four privilege levels checks the whole priority chain against a behavioural model, with monitor mode and the narrow level-3 state varied on their own.

// File: rtl/venab_pkg.sv
package venab_pkg;
  typedef enum logic [2:0] {
    OC_UNDEF = 3'd0,
    OC_TRAP2 = 3'd1,
    OC_TRAP3 = 3'd2,
    OC_VIRT  = 3'd3,
    OC_PHYS  = 3'd4
  } oc_e;
  localparam int OUT_W   = 5;
  localparam int TGT_W   = 2;
  localparam int CLASS_W = 6;
  localparam int NLVL    = 3;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h03;
endpackage

// File: rtl/venab_decode.sv
module venab_decode #(
  parameter int          CP_W  = 4,
  parameter int          OP_W  = 3,
  parameter int          CR_W  = 4,
  parameter logic [3:0]  M_CP  = 4'd15,
  parameter logic [2:0]  M_OP1 = 3'd0,
  parameter logic [3:0]  M_CRN = 4'd12,
  parameter logic [3:0]  M_CRM = 4'd12,
  parameter logic [2:0]  M_OP2 = 3'd6
) (
  input  logic            valid_i,
  input  logic [CP_W-1:0] cp_i,
  input  logic [OP_W-1:0] op1_i,
  input  logic [CR_W-1:0] crn_i,
  input  logic [CR_W-1:0] crm_i,
  input  logic [OP_W-1:0] op2_i,
  output logic            hit_o
);
  assign hit_o = valid_i && (cp_i == CP_W'(M_CP)) && (op1_i == OP_W'(M_OP1)) &&
                 (crn_i == CR_W'(M_CRN)) && (crm_i == CR_W'(M_CRM)) &&
                 (op2_i == OP_W'(M_OP2));
endmodule

// File: rtl/venab_resolve.sv
module venab_resolve
  import venab_pkg::*;
(
  input  logic [1:0]      priv_i,
  input  logic            mon_mode_i,
  input  logic            l2_present_i,
  input  logic            l3_present_i,
  input  logic            l3_narrow_i,
  input  logic            feat_l1_i,
  input  logic            feat_sysif_i,
  input  logic            hyp_cp12_trap_i,
  input  logic            hyp_trap_g0_i,
  input  logic            hyp_virt_fast_i,
  input  logic            route_fast_l3_i,
  input  logic            sdu_prio_i,
  input  logic            sdu_undef_i,
  input  logic [NLVL-1:0] sysif_en_i,
  output oc_e             oc_o
);
  logic route_l2, route_l1;
  oc_e  l3_path;

  assign route_l2 = l3_present_i && route_fast_l3_i;
  // narrow top level: monitor mode is exempt from routing at level 1
  assign route_l1 = route_l2 && (!l3_narrow_i || !mon_mode_i);

  always_comb begin
    oc_o    = OC_PHYS;
    l3_path = sdu_undef_i ? OC_UNDEF : OC_TRAP3;
    if (!feat_l1_i || !feat_sysif_i || priv_i == 2'd0) begin
      oc_o = OC_UNDEF;
    end else begin
      unique case (priv_i)
        2'd1: begin
          if (sdu_prio_i && route_l1)                 oc_o = OC_UNDEF;
          else if (l2_present_i && hyp_cp12_trap_i)   oc_o = OC_TRAP2;
          else if (!sysif_en_i[0])                    oc_o = OC_UNDEF;
          else if (l2_present_i && hyp_trap_g0_i)     oc_o = OC_TRAP2;
          else if (l2_present_i && hyp_virt_fast_i)   oc_o = OC_VIRT;
          else if (route_l1)                          oc_o = l3_path;
          else                                        oc_o = OC_PHYS;
        end
        2'd2: begin
          if (sdu_prio_i && route_l2)                 oc_o = OC_UNDEF;
          else if (!sysif_en_i[1])                    oc_o = OC_UNDEF;
          else if (route_l2)                          oc_o = l3_path;
          else                                        oc_o = OC_PHYS;
        end
        default: begin
          if (!sysif_en_i[2])                         oc_o = OC_UNDEF;
          else                                        oc_o = OC_PHYS;
        end
      endcase
    end
  end
endmodule

// File: rtl/venab_enables.sv
module venab_enables #(
  parameter int NCOPY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [NCOPY-1:0] sel_i,
  input  logic             wbit_i,
  output logic [NCOPY-1:0] en_o
);
  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                en_o[g] <= 1'b0;
      else if (wr_i && sel_i[g])  en_o[g] <= wbit_i;
    end
  end
endmodule

// File: rtl/venab_arbiter.sv
module venab_arbiter
  import venab_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CP_W   = 4,
  parameter int OP_W   = 3,
  parameter int CR_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [CP_W-1:0]    req_cp_i,
  input  logic [OP_W-1:0]    req_op1_i,
  input  logic [CR_W-1:0]    req_crn_i,
  input  logic [CR_W-1:0]    req_crm_i,
  input  logic [OP_W-1:0]    req_op2_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  input  logic [1:0]         priv_i,
  input  logic               mon_mode_i,
  input  logic               l2_present_i,
  input  logic               l3_present_i,
  input  logic               l3_narrow_i,
  input  logic               feat_l1_i,
  input  logic               feat_sysif_i,
  input  logic               hyp_cp12_trap_i,
  input  logic               hyp_trap_g0_i,
  input  logic               hyp_virt_fast_i,
  input  logic               route_fast_l3_i,
  input  logic               sdu_prio_i,
  input  logic               sdu_undef_i,
  input  logic [NLVL-1:0]    sysif_en_i,
  output logic               rsp_valid_o,
  output logic [OUT_W-1:0]   rsp_outcome_o,
  output logic [TGT_W-1:0]   rsp_target_o,
  output logic [CLASS_W-1:0] rsp_class_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic               virt_en_o,
  output logic               phys_en_o
);
  localparam int NCOPY = 2;
  localparam int IDX_V = 0;
  localparam int IDX_P = 1;

  logic             hit;
  oc_e              oc;
  logic [NCOPY-1:0] sel, en;
  logic             rbit, is_trap;

  venab_decode #(.CP_W(CP_W), .OP_W(OP_W), .CR_W(CR_W)) u_dec (
    .valid_i(req_valid_i), .cp_i(req_cp_i), .op1_i(req_op1_i),
    .crn_i(req_crn_i), .crm_i(req_crm_i), .op2_i(req_op2_i), .hit_o(hit)
  );

  venab_resolve u_res (
    .priv_i(priv_i), .mon_mode_i(mon_mode_i), .l2_present_i(l2_present_i),
    .l3_present_i(l3_present_i), .l3_narrow_i(l3_narrow_i),
    .feat_l1_i(feat_l1_i), .feat_sysif_i(feat_sysif_i),
    .hyp_cp12_trap_i(hyp_cp12_trap_i), .hyp_trap_g0_i(hyp_trap_g0_i),
    .hyp_virt_fast_i(hyp_virt_fast_i), .route_fast_l3_i(route_fast_l3_i),
    .sdu_prio_i(sdu_prio_i), .sdu_undef_i(sdu_undef_i),
    .sysif_en_i(sysif_en_i), .oc_o(oc)
  );

  assign sel[IDX_V] = (oc == OC_VIRT);
  assign sel[IDX_P] = (oc == OC_PHYS);

  venab_enables #(.NCOPY(NCOPY)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(hit && req_write_i),
    .sel_i(sel), .wbit_i(req_wdata_i[0]), .en_o(en)
  );

  assign virt_en_o = en[IDX_V];
  assign phys_en_o = en[IDX_P];
  assign rbit      = !req_write_i && |(sel & en);
  assign is_trap   = (oc == OC_TRAP2) || (oc == OC_TRAP3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_outcome_o <= '0;
      rsp_target_o  <= '0;
      rsp_class_o   <= '0;
      rsp_rdata_o   <= '0;
    end else begin
      rsp_valid_o   <= hit;
      rsp_outcome_o <= hit ? (OUT_W'(1) << oc) : '0;
      rsp_target_o  <= !hit ? '0 : (oc == OC_TRAP2) ? TGT_W'(2) :
                       (oc == OC_TRAP3) ? TGT_W'(3) : '0;
      rsp_class_o   <= (hit && is_trap) ? TRAP_CLASS : '0;
      rsp_rdata_o   <= hit ? DATA_W'(rbit) : '0;
    end
  end
endmodule

// File: rtl/venab_arbiter_chk.sv
module venab_arbiter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hit,
  input logic [1:0]  priv_i,
  input logic        req_write_i,
  input logic [2:0]  sysif_en_i,
  input logic        feat_l1_i,
  input logic        feat_sysif_i,
  input logic        rsp_valid_o,
  input logic [4:0]  rsp_outcome_o,
  input logic [1:0]  rsp_target_o,
  input logic [5:0]  rsp_class_o,
  input logic [31:0] rsp_rdata_o,
  input logic        virt_en_o,
  input logic        phys_en_o
);
  AST_NO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> !rsp_valid_o); // R1
  AST_L0_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && priv_i == 2'd0) |=> rsp_outcome_o == 5'b00001); // R2
  AST_L3_PHYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && priv_i == 2'd3 && feat_l1_i && feat_sysif_i && sysif_en_i[2])
      |=> rsp_outcome_o == 5'b10000); // R6
  AST_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones(rsp_outcome_o) == 1); // R7
  AST_TRAP_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (rsp_outcome_o[1] || rsp_outcome_o[2]))
      |-> (rsp_class_o == 6'h03 && rsp_target_o == (rsp_outcome_o[1] ? 2'd2 : 2'd3))); // R7
  AST_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_outcome_o[3] || rsp_outcome_o[4]) |-> rsp_rdata_o == 32'd0); // R8
  AST_RDATA_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_rdata_o[31:1] == 31'd0); // R8
  AST_NO_LEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && |rsp_outcome_o[2:0]) |-> ($stable(virt_en_o) && $stable(phys_en_o))); // R9
  AST_READ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !req_write_i) |=> ($stable(virt_en_o) && $stable(phys_en_o))); // R9
endmodule

bind venab_arbiter venab_arbiter_chk chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hit(hit), .priv_i(priv_i),
  .req_write_i(req_write_i), .sysif_en_i(sysif_en_i),
  .feat_l1_i(feat_l1_i), .feat_sysif_i(feat_sysif_i),
  .rsp_valid_o(rsp_valid_o), .rsp_outcome_o(rsp_outcome_o),
  .rsp_target_o(rsp_target_o), .rsp_class_o(rsp_class_o),
  .rsp_rdata_o(rsp_rdata_o), .virt_en_o(virt_en_o), .phys_en_o(phys_en_o)
);

// File: tb/tb_venab_arbiter.sv
module tb_venab_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid, req_write;
  logic [3:0]  req_cp, req_crn, req_crm;
  logic [2:0]  req_op1, req_op2;
  logic [31:0] req_wdata;
  logic [1:0]  priv;
  logic        mon_mode, l2p, l3p, l3n, f_l1, f_si;
  logic        cp12, tg0, vfast, route, sprio, sundef;
  logic [2:0]  sien;
  logic        rsp_valid;
  logic [4:0]  rsp_out;
  logic [1:0]  rsp_tgt;
  logic [5:0]  rsp_cls;
  logic [31:0] rsp_rd;
  logic        virt_en, phys_en;

  venab_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_cp_i(req_cp), .req_op1_i(req_op1), .req_crn_i(req_crn), .req_crm_i(req_crm),
    .req_op2_i(req_op2), .req_wdata_i(req_wdata), .priv_i(priv), .mon_mode_i(mon_mode),
    .l2_present_i(l2p), .l3_present_i(l3p), .l3_narrow_i(l3n), .feat_l1_i(f_l1),
    .feat_sysif_i(f_si), .hyp_cp12_trap_i(cp12), .hyp_trap_g0_i(tg0),
    .hyp_virt_fast_i(vfast), .route_fast_l3_i(route), .sdu_prio_i(sprio),
    .sdu_undef_i(sundef), .sysif_en_i(sien), .rsp_valid_o(rsp_valid),
    .rsp_outcome_o(rsp_out), .rsp_target_o(rsp_tgt), .rsp_class_o(rsp_cls),
    .rsp_rdata_o(rsp_rd), .virt_en_o(virt_en), .phys_en_o(phys_en)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic mv = 1'b0, mp = 1'b0;  // model enables

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural outcome: 0 undef, 1 trap L2, 2 trap L3, 3 virtual, 4 physical, -1 none
  function automatic int ref_oc();
    bit to_top, to_top1;
    if (!(req_valid && req_cp == 4'd15 && req_op1 == 3'd0 && req_crn == 4'd12 &&
          req_crm == 4'd12 && req_op2 == 3'd6)) return -1;
    if (priv == 2'd0 || !f_l1 || !f_si) return 0;
    to_top  = l3p && route;
    to_top1 = to_top && !(l3n && mon_mode);
    case (priv)
      2'd1: begin
        if (sprio && to_top1) return 0;
        if (l2p && cp12)      return 1;
        if (!sien[0])         return 0;
        if (l2p && tg0)       return 1;
        if (l2p && vfast)     return 3;
        if (to_top1)          return sundef ? 0 : 2;
        return 4;
      end
      2'd2: begin
        if (sprio && to_top)  return 0;
        if (!sien[1])         return 0;
        if (to_top)           return sundef ? 0 : 2;
        return 4;
      end
      default: return sien[2] ? 4 : 0;
    endcase
  endfunction

  task automatic tick(input string tag);
    int oc;
    logic [4:0]  e_out;
    logic [1:0]  e_tgt;
    logic [5:0]  e_cls;
    logic [31:0] e_rd;
    oc    = ref_oc();
    e_out = (oc >= 0) ? 5'(1 << oc) : 5'd0;
    e_tgt = (oc == 1) ? 2'd2 : (oc == 2) ? 2'd3 : 2'd0;
    e_cls = (oc == 1 || oc == 2) ? 6'h03 : 6'h00;
    e_rd  = 32'd0;
    if (!req_write && oc == 3) e_rd = {31'd0, mv};
    if (!req_write && oc == 4) e_rd = {31'd0, mp};
    if (req_write && oc == 3) mv = req_wdata[0];
    if (req_write && oc == 4) mp = req_wdata[0];
    @(posedge clk);
    @(negedge clk);
    check(tag, {49'd0, rsp_valid, rsp_out, rsp_tgt, rsp_cls},
               {49'd0, (oc >= 0), e_out, e_tgt, e_cls});
    check({tag, "/R8"}, {32'd0, rsp_rd}, {32'd0, e_rd});
    check({tag, "/R9"}, {62'd0, virt_en, phys_en}, {62'd0, mv, mp});
  endtask

  task automatic base();
    req_valid = 1'b1; req_write = 1'b0; req_cp = 4'd15; req_op1 = 3'd0;
    req_crn = 4'd12; req_crm = 4'd12; req_op2 = 3'd6; req_wdata = 32'd0;
    priv = 2'd1; mon_mode = 0; l2p = 1; l3p = 1; l3n = 0; f_l1 = 1; f_si = 1;
    cp12 = 0; tg0 = 0; vfast = 0; route = 0; sprio = 0; sundef = 0; sien = 3'b111;
  endtask

  task automatic access(input logic wr, input logic [31:0] d, input string tag);
    req_write = wr; req_wdata = d;
    tick(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    base();
    req_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10", {61'd0, rsp_valid, virt_en, phys_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {61'd0, rsp_valid, virt_en, phys_en}, 64'd0);

    // R1: idle, near-miss encodings
    base(); req_valid = 1'b0; req_write = 1; req_wdata = 1; tick("R1");
    base(); req_crm = 4'd11; req_write = 1; req_wdata = 1; tick("R1");
    base(); req_op2 = 3'd7; tick("R1");
    base(); req_cp = 4'd14; tick("R1");

    // R2
    base(); priv = 2'd0; access(1, 1, "R2");
    base(); priv = 2'd3; f_l1 = 0; access(1, 1, "R2");
    base(); priv = 2'd2; f_si = 0; tick("R2");

    // R4 baseline physical, then virtual
    base(); access(1, 1, "R4"); access(0, 0, "R4");
    base(); vfast = 1; access(1, 32'hFFFF_FFFF, "R4"); access(0, 0, "R4");
    base(); vfast = 1; l2p = 0; tick("R4");
    base(); route = 1; tick("R4");
    base(); route = 1; sundef = 1; tick("R4");
    base(); route = 1; l3n = 1; mon_mode = 1; tick("R4");
    base(); route = 1; l3p = 0; tick("R4");

    // R3 priority: add higher controls one at a time
    base(); vfast = 1; tg0 = 1; access(1, 0, "R3");
    base(); vfast = 1; tg0 = 1; sien[0] = 0; access(1, 0, "R3");
    base(); vfast = 1; tg0 = 1; sien[0] = 0; cp12 = 1; access(1, 0, "R3");
    base(); vfast = 1; tg0 = 1; sien[0] = 0; cp12 = 1; route = 1; sprio = 1; access(1, 0, "R3");
    base(); cp12 = 1; route = 1; sprio = 1; l3n = 1; mon_mode = 1; tick("R3");
    base(); cp12 = 1; l2p = 0; tg0 = 1; tick("R3");

    // R9: trapped/undef writes leave enables, upper bits ignored
    base(); cp12 = 1; access(1, 0, "R9");
    base(); priv = 2'd0; access(1, 0, "R9");
    base(); access(1, 32'hFFFF_FFFE, "R9"); access(0, 0, "R9");
    base(); vfast = 1; access(1, 32'h8000_0000, "R9"); access(0, 0, "R9");

    // R5
    base(); priv = 2'd2; access(1, 1, "R5"); access(0, 0, "R5");
    base(); priv = 2'd2; sien[1] = 0; tick("R5");
    base(); priv = 2'd2; route = 1; tick("R5");
    base(); priv = 2'd2; route = 1; sundef = 1; tick("R5");
    base(); priv = 2'd2; route = 1; sprio = 1; sien[1] = 0; l3n = 1; mon_mode = 1; tick("R5");
    base(); priv = 2'd2; vfast = 1; cp12 = 1; tick("R5");

    // R6
    base(); priv = 2'd3; route = 1; sprio = 1; access(1, 0, "R6"); access(0, 0, "R6");
    base(); priv = 2'd3; sien[2] = 0; tick("R6");

    // R7: back-to-back responses and gap
    base(); route = 1; tick("R7"); cp12 = 1; tick("R7"); req_valid = 0; tick("R7");

    // randomized sweep
    for (int i = 0; i < 3000; i++) begin
      base();
      req_valid = ($urandom % 8) != 0;
      if (($urandom % 10) == 0) req_crn = 4'($urandom);
      req_write = 1'($urandom); req_wdata = $urandom;
      priv = 2'($urandom); mon_mode = 1'($urandom); l2p = 1'($urandom);
      l3p = 1'($urandom); l3n = 1'($urandom);
      f_l1 = ($urandom % 16) != 0; f_si = ($urandom % 16) != 0;
      cp12 = ($urandom % 4) == 0; tg0 = ($urandom % 4) == 0; vfast = 1'($urandom);
      route = 1'($urandom); sprio = 1'($urandom); sundef = 1'($urandom);
      sien = 3'($urandom | $urandom);
      case (priv)
        2'd0: tick("R2");
        2'd1: tick("R3");
        2'd2: tick("R5");
        default: tick("R6");
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule